// File: doc/BRIEF.md
# System Power State Monitor

This block watches the reported states of four supply sets and names the system power state that they form. Supply sets A, B and D each report a single on/off bit. Supply set C reports a two-bit mode: off, nominal or turbo. Every clock edge captures one sample of the four inputs. A fixed priority table then decodes that sample into one of five named system states, or into "undefined" when no entry matches. The table is treated as complete, so an undefined sample is an illegal state.

The block remembers the last defined state it decoded. Each newly decoded state that differs from it is classified against an explicit transition list as legal, illegal or unlisted, and exactly one flag is raised. For coverage, saturating counters record how many times each defined state is entered and how many times each legal transition is taken. A power-aware bench or an on-chip monitor can read these counts to show which power scenarios were exercised.

Top module: `pwr_state_monitor`

## Requirements
- R1: The inputs are captured at each rising clock edge. Until the next edge, every flag and `state_o` describe that captured sample and the remembered previous state.
- R2: Supply set C modes are 2'b00 off, 2'b01 nominal and 2'b10 turbo; "C up" means nominal or turbo. The five states and their `state_o` codes are:
  - FULL (0): A, B and D on, C up.
  - A_DN (1): A off, D on, C up.
  - B_DN (2): A on, B off, D on, C up.
  - ALL_DN (3): A, B and D off, C up.
  - AD_DN (4): A off, D off, C up.
- R3: When several definitions match, the lowest code wins. An all-off sample with C up therefore decodes as ALL_DN (3), not AD_DN (4).
- R4: A captured sample that matches no state gives `state_o`=7 and `illegal_state_o`=1. Supply set C modes 2'b00 and 2'b11 always fall in this case.
- R5: An undefined sample leaves the remembered previous state unchanged. The first defined sample after reset is not a transition.
- R6: The legal transitions, with their `trans_idx_o` values, are:
  - FULL→A_DN (0)
  - FULL→B_DN (1)
  - A_DN→FULL (2)
  - A_DN→B_DN (3)
  - A_DN→AD_DN (4)
  
  Each raises `legal_trans_o`. `trans_idx_o` is 0 whenever `legal_trans_o` is low.
- R7: FULL→ALL_DN and ALL_DN→FULL raise `illegal_trans_o`.
- R8: Any other change between two different defined states raises `unlisted_trans_o`. At most one of the three transition flags is high at a time.
- R9: A defined sample equal to the remembered state raises no transition flag.
- R10: Counter k of `state_cnt_o` (bits k*CNT_W upward) counts entries into state k. An entry is the first defined sample after reset or a defined sample that differs from the remembered state. The counter saturates at its maximum value. It updates at the edge after the entry is flagged.
- R11: Counter i of `trans_cnt_o` counts legal transitions with index i. It saturates at its maximum value and updates at the edge after the transition is flagged.
- R12: During and just after reset, `state_o`=7, all flags are 0 and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ssa_on_i | input | 1 | Supply set A on |
| ssb_on_i | input | 1 | Supply set B on |
| ssc_mode_i | input | 2 | Supply set C mode: 00 off, 01 nominal, 10 turbo |
| ssd_on_i | input | 1 | Supply set D on |
| state_o | output | 3 | Decoded state code, 7 when undefined or no sample yet |
| illegal_state_o | output | 1 | Captured sample matches no state |
| legal_trans_o | output | 1 | Listed legal transition |
| trans_idx_o | output | 3 | Index of the legal transition |
| illegal_trans_o | output | 1 | Listed forbidden transition |
| unlisted_trans_o | output | 1 | Change not in either list |
| state_cnt_o | output | 5*CNT_W | State entry counters, state 0 in the low bits |
| trans_cnt_o | output | 5*CNT_W | Legal transition counters, index 0 in the low bits |

## Verification
The assertions check several properties on every cycle:
- the transition flags are mutually exclusive;
- a repeated state raises no flag;
- an undefined sample leaves the remembered state frozen;
- C off or reserved always flags an illegal state;
- the two forbidden transitions are always flagged;
- counters hold once saturated.

Only the bench's scenarios can show the following: the decoded code for each of the 32 input combinations, the priority between overlapping definitions, and the class of every ordered pair of states. The same applies to first-sample behaviour after reset and to the exact counter values, both below and at saturation.

// File: rtl/psm_pkg.sv
package psm_pkg;
  typedef enum logic [2:0] {
    ST_FULL   = 3'd0,
    ST_A_DN   = 3'd1,
    ST_B_DN   = 3'd2,
    ST_ALL_DN = 3'd3,
    ST_AD_DN  = 3'd4,
    ST_UNDEF  = 3'd7
  } sys_st_e;

  typedef enum logic [1:0] {
    TC_NONE,
    TC_LEGAL,
    TC_ILLEGAL,
    TC_UNLISTED
  } tcls_e;

  localparam int unsigned N_ST  = 5;
  localparam int unsigned N_LT  = 5;
  localparam logic [1:0] C_OFF = 2'b00;
  localparam logic [1:0] C_NOM = 2'b01;
  localparam logic [1:0] C_TRB = 2'b10;
endpackage

// File: rtl/psm_decode.sv
module psm_decode
  import psm_pkg::*;
(
  input  logic       a_on_i,
  input  logic       b_on_i,
  input  logic [1:0] c_mode_i,
  input  logic       d_on_i,
  output sys_st_e    st_o
);
  logic             c_up;
  logic [N_ST-1:0]  hit;

  assign c_up = (c_mode_i == C_NOM) || (c_mode_i == C_TRB);

  always_comb begin
    hit = '0;
    hit[ST_FULL]   = c_up &  a_on_i &  b_on_i &  d_on_i;
    hit[ST_A_DN]   = c_up & ~a_on_i &  d_on_i;
    hit[ST_B_DN]   = c_up &  a_on_i & ~b_on_i &  d_on_i;
    hit[ST_ALL_DN] = c_up & ~a_on_i & ~b_on_i & ~d_on_i;
    hit[ST_AD_DN]  = c_up & ~a_on_i & ~d_on_i;
  end

  // lowest code wins
  always_comb begin
    st_o = ST_UNDEF;
    for (int k = N_ST - 1; k >= 0; k--) begin
      if (hit[k]) st_o = sys_st_e'(3'(k));
    end
  end
endmodule

// File: rtl/psm_trans.sv
module psm_trans
  import psm_pkg::*;
(
  input  logic       prev_vld_i,
  input  sys_st_e    prev_i,
  input  sys_st_e    cur_i,
  output tcls_e      cls_o,
  output logic [2:0] idx_o
);
  always_comb begin
    cls_o = TC_NONE;
    idx_o = 3'd0;
    if (prev_vld_i && cur_i != ST_UNDEF && cur_i != prev_i) begin
      cls_o = TC_UNLISTED;
      unique case (prev_i)
        ST_FULL: begin
          if (cur_i == ST_A_DN)        begin cls_o = TC_LEGAL; idx_o = 3'd0; end
          else if (cur_i == ST_B_DN)   begin cls_o = TC_LEGAL; idx_o = 3'd1; end
          else if (cur_i == ST_ALL_DN) cls_o = TC_ILLEGAL;
        end
        ST_A_DN: begin
          if (cur_i == ST_FULL)        begin cls_o = TC_LEGAL; idx_o = 3'd2; end
          else if (cur_i == ST_B_DN)   begin cls_o = TC_LEGAL; idx_o = 3'd3; end
          else if (cur_i == ST_AD_DN)  begin cls_o = TC_LEGAL; idx_o = 3'd4; end
        end
        ST_ALL_DN: begin
          if (cur_i == ST_FULL) cls_o = TC_ILLEGAL;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/psm_cov.sv
module psm_cov
  import psm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_ST-1:0]       st_inc_i,
  input  logic [N_LT-1:0]       tr_inc_i,
  output logic [N_ST*CNT_W-1:0] st_cnt_o,
  output logic [N_LT*CNT_W-1:0] tr_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar k = 0; k < N_ST; k++) begin : g_st
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            cnt_q <= '0;
      else if (st_inc_i[k] && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
    assign st_cnt_o[k*CNT_W +: CNT_W] = cnt_q;

    p_cnt_sat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  end

  for (genvar i = 0; i < N_LT; i++) begin : g_tr
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            cnt_q <= '0;
      else if (tr_inc_i[i] && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
    assign tr_cnt_o[i*CNT_W +: CNT_W] = cnt_q;

    p_cnt_sat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  end
endmodule

// File: rtl/pwr_state_monitor.sv
module pwr_state_monitor
  import psm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ssa_on_i,
  input  logic                  ssb_on_i,
  input  logic [1:0]            ssc_mode_i,
  input  logic                  ssd_on_i,
  output logic [2:0]            state_o,
  output logic                  illegal_state_o,
  output logic                  legal_trans_o,
  output logic [2:0]            trans_idx_o,
  output logic                  illegal_trans_o,
  output logic                  unlisted_trans_o,
  output logic [N_ST*CNT_W-1:0] state_cnt_o,
  output logic [N_LT*CNT_W-1:0] trans_cnt_o
);
  logic       smp_vld_q, a_q, b_q, d_q;
  logic [1:0] c_q;
  sys_st_e    cur, prev_q;
  logic       prev_vld_q;
  logic       undef;
  tcls_e      cls;
  logic [2:0] idx;
  logic [N_ST-1:0] st_inc;
  logic [N_LT-1:0] tr_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_vld_q <= 1'b0;
      a_q <= 1'b0; b_q <= 1'b0; d_q <= 1'b0; c_q <= C_OFF;
    end else begin
      smp_vld_q <= 1'b1;
      a_q <= ssa_on_i; b_q <= ssb_on_i; d_q <= ssd_on_i; c_q <= ssc_mode_i;
    end
  end

  sys_st_e dec_st;
  psm_decode u_dec (
    .a_on_i(a_q), .b_on_i(b_q), .c_mode_i(c_q), .d_on_i(d_q), .st_o(dec_st)
  );

  assign cur   = smp_vld_q ? dec_st : ST_UNDEF;
  assign undef = smp_vld_q && (dec_st == ST_UNDEF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= ST_UNDEF;
      prev_vld_q <= 1'b0;
    end else if (smp_vld_q && !undef) begin
      prev_q     <= cur;
      prev_vld_q <= 1'b1;
    end
  end

  psm_trans u_trans (
    .prev_vld_i(prev_vld_q), .prev_i(prev_q), .cur_i(cur),
    .cls_o(cls), .idx_o(idx)
  );

  for (genvar k = 0; k < N_ST; k++) begin : g_sinc
    assign st_inc[k] = smp_vld_q && !undef && (cur == sys_st_e'(3'(k))) &&
                       (!prev_vld_q || cur != prev_q);
  end
  for (genvar i = 0; i < N_LT; i++) begin : g_tinc
    assign tr_inc[i] = (cls == TC_LEGAL) && (idx == 3'(i));
  end

  psm_cov #(.CNT_W(CNT_W)) u_cov (
    .clk_i(clk_i), .rst_ni(rst_ni), .st_inc_i(st_inc), .tr_inc_i(tr_inc),
    .st_cnt_o(state_cnt_o), .tr_cnt_o(trans_cnt_o)
  );

  assign state_o          = cur;
  assign illegal_state_o  = undef;
  assign legal_trans_o    = (cls == TC_LEGAL);
  assign trans_idx_o      = idx;
  assign illegal_trans_o  = (cls == TC_ILLEGAL);
  assign unlisted_trans_o = (cls == TC_UNLISTED);

  p_prev_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef |=> ($stable(prev_q) && $stable(prev_vld_q)));

  p_one_class_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({legal_trans_o, illegal_trans_o, unlisted_trans_o}));

  p_no_trans_same_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_vld_q && cur == prev_q) |->
      !(legal_trans_o || illegal_trans_o || unlisted_trans_o));

  p_forbidden_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_vld_q && ((prev_q == ST_ALL_DN && cur == ST_FULL) ||
                    (prev_q == ST_FULL && cur == ST_ALL_DN))) |-> illegal_trans_o);

  p_c_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_q && c_q != C_NOM && c_q != C_TRB) |-> (illegal_state_o && state_o == 3'd7));
endmodule

// File: tb/pwr_state_monitor_test.sv
module pwr_state_monitor_test;
  localparam int CW  = 8;
  localparam int MAXC = 255;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a = 0, b = 0, d = 0;
  logic [1:0] c = 0;
  logic [2:0] st;
  logic ist, ltr, itr, utr;
  logic [2:0] tidx;
  logic [5*CW-1:0] scnt, tcnt;

  int total = 0, bad = 0;
  int m_prev = 7, m_pv = 0;
  int m_sc[5], m_tc[5];
  bit done = 0;

  always #10 clk = ~clk;

  pwr_state_monitor #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ssa_on_i(a), .ssb_on_i(b), .ssc_mode_i(c),
    .ssd_on_i(d), .state_o(st), .illegal_state_o(ist), .legal_trans_o(ltr),
    .trans_idx_o(tidx), .illegal_trans_o(itr), .unlisted_trans_o(utr),
    .state_cnt_o(scnt), .trans_cnt_o(tcnt)
  );

  function automatic int dec(input int v);
    int sa = v & 1, sb = (v >> 1) & 1, sd = (v >> 2) & 1, sc = (v >> 3) & 3;
    bit up = (sc == 1) || (sc == 2);
    if (!up) return 7;
    if (sa && sb && sd) return 0;
    if (!sa && sd) return 1;
    if (sa && !sb && sd) return 2;
    if (!sa && !sb && !sd) return 3;
    if (!sa && !sd) return 4;
    return 7;
  endfunction

  // 0 none, 1 legal, 2 illegal, 3 unlisted; lidx out
  function automatic int cls(input int pv, input int p, input int cu, output int lidx);
    lidx = 0;
    if (!pv || cu == 7 || cu == p) return 0;
    if (p == 0 && cu == 1) begin lidx = 0; return 1; end
    if (p == 0 && cu == 2) begin lidx = 1; return 1; end
    if (p == 1 && cu == 0) begin lidx = 2; return 1; end
    if (p == 1 && cu == 2) begin lidx = 3; return 1; end
    if (p == 1 && cu == 4) begin lidx = 4; return 1; end
    if ((p == 0 && cu == 3) || (p == 3 && cu == 0)) return 2;
    return 3;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk_cnts();
    for (int k = 0; k < 5; k++) chk("R10 state count", int'(scnt[k*CW +: CW]), m_sc[k]);
    for (int k = 0; k < 5; k++) chk("R11 trans count", int'(tcnt[k*CW +: CW]), m_tc[k]);
  endtask

  // called at a negedge: drive, wait one cycle, check, update model
  task automatic apply(input int v);
    int e, k, li;
    a = v[0]; b = v[1]; d = v[2]; c = v[4:3];
    @(negedge clk);
    e = dec(v);
    chk((!v[0] && !v[2]) ? "R1 R2 R3 state" : "R1 R2 state", int'(st), e);
    chk("R4 illegal state", int'(ist), e == 7 ? 1 : 0);
    k = cls(m_pv, m_prev, e, li);
    if (k == 1) begin
      chk("R6 legal", int'(ltr), 1); chk("R6 index", int'(tidx), li);
    end else begin
      chk("R6 no legal", int'(ltr), 0); chk("R6 index zero", int'(tidx), 0);
    end
    chk("R7 illegal trans", int'(itr), k == 2 ? 1 : 0);
    chk("R8 unlisted", int'(utr), k == 3 ? 1 : 0);
    if (e != 7 && e == m_prev && m_pv)
      chk("R9 repeat", int'(ltr | itr | utr), 0);
    if (e != 7 && !m_pv)
      chk("R5 first sample", int'(ltr | itr | utr), 0);
    chk_cnts();
    if (e != 7) begin
      if ((!m_pv || e != m_prev) && m_sc[e] < MAXC) m_sc[e]++;
      if (k == 1 && m_tc[li] < MAXC) m_tc[li]++;
      m_prev = e; m_pv = 1;
    end
  endtask

  function automatic int enc(input int sa, input int sb, input int sd, input int sc);
    return sa | (sb << 1) | (sd << 2) | (sc << 3);
  endfunction

  initial begin
    for (int k = 0; k < 5; k++) begin m_sc[k] = 0; m_tc[k] = 0; end
    @(negedge clk); @(negedge clk);
    chk("R12 reset state", int'(st), 7);
    chk("R12 reset flags", int'({ist, ltr, itr, utr}), 0);
    chk("R12 reset counts", int'(|{scnt, tcnt}), 0);
    rst_n = 1'b1;
    // directed
    apply(enc(0, 0, 0, 0));   // undefined first
    apply(enc(1, 1, 1, 1));   // FULL, first defined
    apply(enc(0, 1, 1, 2));   // A_DN legal
    apply(enc(0, 1, 0, 1));   // AD_DN legal
    apply(enc(0, 0, 0, 2));   // ALL_DN unlisted, R3 priority
    apply(enc(1, 1, 1, 2));   // ALL->FULL illegal
    apply(enc(1, 1, 1, 1));   // repeat
    apply(enc(1, 1, 1, 3));   // reserved mode
    apply(enc(1, 1, 1, 1));   // same as held prev
    apply(enc(1, 0, 1, 1));   // B_DN legal
    apply(enc(1, 0, 0, 1));   // undefined: A on, D off
    apply(enc(0, 1, 1, 1));   // B->A unlisted
    apply(enc(1, 0, 1, 2));   // A->B legal
    apply(enc(1, 1, 1, 1));   // B->FULL unlisted
    apply(enc(0, 0, 0, 1));   // FULL->ALL illegal
    // sweep every ordered pair of the 32 combinations
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++) begin
        apply(i);
        apply(j);
      end
    apply(enc(1, 1, 1, 1));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule